// File: doc/BRIEF.md
# Dual-Bank OUT Endpoint Receive Manager

This block handles the receive side of a bulk or interrupt OUT endpoint whose packet buffer is one bank or two. The serial-bus side opens a packet with a token strobe, streams bytes into the bank it currently owns, and closes the packet with an end strobe. At that moment the block answers with an ACK pulse if the packet was taken, or a NAK pulse if no bank was free when the token came.

Completed banks pass to the processor side in the order they were filled. A presented bank raises two bits: a packet flag, which drives the interrupt through an enable input, and a bank-busy bit, which marks processor ownership. The processor reads the bank byte by byte and sees its byte count. It then writes the two bits back. Clearing the packet flag only acknowledges the interrupt. Clearing bank-busy returns the bank to the receive side and moves the read side on to the next full bank.

The byte storage is a plain register array. Packet decoding and CRC are handled outside this block.

Top module: `oep_out_bank_mgr`

## Requirements
- R1: While `cfg_enable` is low the block gives no handshake, stores nothing, and holds `pkt_flag`, `bank_busy`, `cpu_count` and `cpu_rdata` at 0. Dropping `cfg_enable` empties every bank and abandons a packet in progress. The same state follows reset.
- R2: A token (`usb_tok`) opens a packet only if a bank is free at that edge. `usb_end` then gives `hs_ack` in the same cycle for an opened packet, and `hs_nak` for one that was not opened. A token in the same cycle as a byte or an end takes precedence over both.
- R3: A bank holding a completed packet is presented to the processor at the first edge where `bank_busy` is low. That is one clock after the committing edge. `pkt_flag` and `bank_busy` rise together at that edge.
- R4: `irq` is high exactly when `pkt_flag` and `irq_en` are both high.
- R5: A CSR write (`csr_wr`) with `csr_flag_val` = 0 clears `pkt_flag` and leaves `bank_busy`, the count and the read position unchanged.
- R6: A CSR write with `csr_busy_val` = 0 while `bank_busy` is high frees the presented bank and resets the read position. If another bank is full, it is presented at the next edge and both bits rise again.
- R7: With `cfg_two_banks` = 1, packets fill the two banks alternately and a token is refused only when both banks are full. With `cfg_two_banks` = 0, a token is refused while the single bank is full.
- R8: Each bank keeps its own byte count. `cpu_count` shows the presented bank's count while `bank_busy` is high, and 0 otherwise. A zero-length packet fills a bank with a count of 0. Bytes beyond `DEPTH` are dropped and the count stops at `DEPTH`.
- R9: While `bank_busy` is high, `cpu_rdata` shows the byte at the read position, and `cpu_rd` advances that position. Bytes come out in the order they were received. Once the position reaches the count, `cpu_rdata` is 0 and `cpu_rd` has no effect.
- R10: A CSR bit written as 1 has no effect. When a clear and a hardware set of the same bit fall in the same cycle, the clear wins: the bit stays 0 and any pending presentation moves to a later edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Endpoint configured and enabled |
| cfg_two_banks | input | 1 | 1 = two banks, 0 = one bank |
| irq_en | input | 1 | Interrupt enable for the packet flag |
| usb_tok | input | 1 | OUT token strobe, opens a packet |
| usb_wr | input | 1 | Received byte strobe |
| usb_wdata | input | DW | Received byte |
| usb_end | input | 1 | End-of-packet strobe |
| hs_ack | output | 1 | Packet accepted (same cycle as usb_end) |
| hs_nak | output | 1 | Packet refused (same cycle as usb_end) |
| cpu_rd | input | 1 | Advance the read position |
| cpu_rdata | output | DW | Byte at the read position |
| cpu_count | output | $clog2(DEPTH+1) | Byte count of the presented bank |
| csr_wr | input | 1 | CSR write strobe for the two bits |
| csr_flag_val | input | 1 | Written packet-flag value (0 clears) |
| csr_busy_val | input | 1 | Written bank-busy value (0 releases) |
| pkt_flag | output | 1 | Packet received flag |
| bank_busy | output | 1 | Presented bank owned by the processor |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of events can land on the same edge. In the first, the receive side commits a packet into one bank while the processor releases the other. The bench provokes this by ending a packet in the very cycle it writes bank-busy to 0 with two banks configured. In the second, a processor clear meets a hardware presentation of the same bit. The bench provokes this by issuing the clear in the cycle right after a packet ends. In both cases the bench's queue-based model gives the expected flags, counts, data and handshakes, and every output is compared with the model on every clock.

// File: rtl/oep_pkg.sv
`timescale 1ns/1ps
package oep_pkg;
  // bank index that follows cur; single-bank mode always stays on bank 0
  function automatic logic next_bank(input logic cur, input logic two);
    return two ? ~cur : 1'b0;
  endfunction

  // a CSR bit written as 0 requests a clear; a written 1 is ignored
  function automatic logic clear_req(input logic wr, input logic val);
    return wr & ~val;
  endfunction
endpackage

// File: rtl/oep_rx_fill.sv
`timescale 1ns/1ps
module oep_rx_fill
  import oep_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          two_banks,
  input  logic          usb_tok,
  input  logic          usb_wr,
  input  logic          usb_end,
  input  logic          bank_free,
  output logic          rx_on,
  output logic          wr_bank,
  output logic [CW-1:0] wptr,
  output logic          wr_en,
  output logic          commit,
  output logic          hs_ack,
  output logic          hs_nak
);
  logic end_evt;

  assign end_evt = enable & usb_end & ~usb_tok;
  assign commit  = end_evt & rx_on;
  assign hs_ack  = commit;
  assign hs_nak  = end_evt & ~rx_on;
  assign wr_en   = enable & usb_wr & ~usb_tok & ~usb_end & rx_on & (wptr < CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      rx_on   <= 1'b0;
      wr_bank <= 1'b0;
      wptr    <= '0;
    end else if (usb_tok) begin
      rx_on <= bank_free;
      wptr  <= '0;
    end else if (usb_end) begin
      rx_on <= 1'b0;
      if (rx_on) wr_bank <= next_bank(wr_bank, two_banks);
    end else if (wr_en) begin
      wptr <= wptr + 1'b1;
    end
  end
endmodule

// File: rtl/oep_bank_store.sv
`timescale 1ns/1ps
module oep_bank_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          wr_en,
  input  logic          wr_bank,
  input  logic [CW-1:0] wptr,
  input  logic [DW-1:0] wdata,
  input  logic          commit,
  input  logic          release_bank,
  input  logic          rd_bank,
  input  logic [CW-1:0] rptr,
  output logic [1:0]    full,
  output logic [CW-1:0] rd_count,
  output logic [DW-1:0] rd_data
);
  localparam int NB = 2;
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] bank_rd  [NB];
  logic [CW-1:0] bank_cnt [NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [DW-1:0] mem_q [DEPTH];
    logic [CW-1:0] cnt_q;
    logic          full_q;

    always_ff @(posedge clk) begin
      if (wr_en && wr_bank == b[0]) mem_q[wptr[IW-1:0]] <= wdata;
    end

    always_ff @(posedge clk) begin
      if (!rst_n || !enable) begin
        cnt_q  <= '0;
        full_q <= 1'b0;
      end else if (commit && wr_bank == b[0]) begin
        cnt_q  <= wptr;
        full_q <= 1'b1;
      end else if (release_bank && rd_bank == b[0]) begin
        full_q <= 1'b0;
      end
    end

    assign bank_rd[b]  = mem_q[rptr[IW-1:0]];
    assign bank_cnt[b] = cnt_q;
    assign full[b]     = full_q;
  end

  assign rd_count = bank_cnt[rd_bank];
  assign rd_data  = (rptr < rd_count) ? bank_rd[rd_bank] : '0;
endmodule

// File: rtl/oep_cpu_ctl.sv
`timescale 1ns/1ps
module oep_cpu_ctl
  import oep_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          two_banks,
  input  logic          csr_wr,
  input  logic          csr_flag_val,
  input  logic          csr_busy_val,
  input  logic          cpu_rd,
  input  logic          irq_en,
  input  logic          rd_full,
  input  logic [CW-1:0] rd_count,
  output logic          busy,
  output logic          flag,
  output logic          irq,
  output logic          rd_bank,
  output logic [CW-1:0] rptr,
  output logic          release_bank,
  output logic          present,
  output logic          flag_clr
);
  logic busy_clr;

  assign flag_clr     = clear_req(csr_wr, csr_flag_val);
  assign busy_clr     = clear_req(csr_wr, csr_busy_val);
  assign release_bank = enable & busy_clr & busy;
  assign present      = enable & ~busy & rd_full & ~busy_clr;
  assign irq          = flag & irq_en;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      busy    <= 1'b0;
      rd_bank <= 1'b0;
      rptr    <= '0;
    end else if (release_bank) begin
      busy    <= 1'b0;
      rd_bank <= next_bank(rd_bank, two_banks);
      rptr    <= '0;
    end else if (present) begin
      busy <= 1'b1;
      rptr <= '0;
    end else if (cpu_rd && busy && rptr < rd_count) begin
      rptr <= rptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) flag <= 1'b0;
    else if (flag_clr)     flag <= 1'b0;
    else if (present)      flag <= 1'b1;
  end
endmodule

// File: rtl/oep_out_bank_mgr.sv
`timescale 1ns/1ps
module oep_out_bank_mgr #(
  parameter int DW    = 8,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_enable,
  input  logic                         cfg_two_banks,
  input  logic                         irq_en,
  input  logic                         usb_tok,
  input  logic                         usb_wr,
  input  logic [DW-1:0]                usb_wdata,
  input  logic                         usb_end,
  output logic                         hs_ack,
  output logic                         hs_nak,
  input  logic                         cpu_rd,
  output logic [DW-1:0]                cpu_rdata,
  output logic [$clog2(DEPTH+1)-1:0]   cpu_count,
  input  logic                         csr_wr,
  input  logic                         csr_flag_val,
  input  logic                         csr_busy_val,
  output logic                         pkt_flag,
  output logic                         bank_busy,
  output logic                         irq
);
  localparam int CW = $clog2(DEPTH + 1);

  // named internal events, visible to the bound checker
  logic          rx_on, wr_bank, wr_en, commit, bank_free;
  logic          rd_bank, release_bank, present, flag_clr;
  logic [CW-1:0] wptr, rptr, rd_count;
  logic [DW-1:0] rd_data;
  logic [1:0]    full;

  assign bank_free = ~full[wr_bank];

  oep_rx_fill #(.DEPTH(DEPTH), .CW(CW)) u_rx (
    .clk(clk), .rst_n(rst_n), .enable(cfg_enable), .two_banks(cfg_two_banks),
    .usb_tok(usb_tok), .usb_wr(usb_wr), .usb_end(usb_end), .bank_free(bank_free),
    .rx_on(rx_on), .wr_bank(wr_bank), .wptr(wptr), .wr_en(wr_en),
    .commit(commit), .hs_ack(hs_ack), .hs_nak(hs_nak)
  );

  oep_bank_store #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_store (
    .clk(clk), .rst_n(rst_n), .enable(cfg_enable), .wr_en(wr_en),
    .wr_bank(wr_bank), .wptr(wptr), .wdata(usb_wdata), .commit(commit),
    .release_bank(release_bank), .rd_bank(rd_bank), .rptr(rptr),
    .full(full), .rd_count(rd_count), .rd_data(rd_data)
  );

  oep_cpu_ctl #(.CW(CW)) u_cpu (
    .clk(clk), .rst_n(rst_n), .enable(cfg_enable), .two_banks(cfg_two_banks),
    .csr_wr(csr_wr), .csr_flag_val(csr_flag_val), .csr_busy_val(csr_busy_val),
    .cpu_rd(cpu_rd), .irq_en(irq_en), .rd_full(full[rd_bank]), .rd_count(rd_count),
    .busy(bank_busy), .flag(pkt_flag), .irq(irq), .rd_bank(rd_bank), .rptr(rptr),
    .release_bank(release_bank), .present(present), .flag_clr(flag_clr)
  );

  assign cpu_count = bank_busy ? rd_count : '0;
  assign cpu_rdata = bank_busy ? rd_data  : '0;
endmodule

// File: rtl/oep_checker.sv
`timescale 1ns/1ps
module oep_checker #(
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_enable,
  input logic          hs_ack,
  input logic          hs_nak,
  input logic          csr_wr,
  input logic          csr_flag_val,
  input logic          csr_busy_val,
  input logic          pkt_flag,
  input logic          bank_busy,
  input logic [CW-1:0] cpu_count,
  input logic          commit,
  input logic          release_bank,
  input logic          wr_bank,
  input logic          rd_bank
);
  // R1: no handshake while unconfigured
  a_r1_silent_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |-> (!hs_ack && !hs_nak));

  // R2: a packet end answers with at most one handshake
  a_r2_one_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_ack && hs_nak));

  // R3: the packet flag only rises together with bank ownership
  a_r3_flag_with_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pkt_flag) |-> $rose(bank_busy));

  // R5: a flag-only clear keeps the bank owned
  a_r5_ack_keeps_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && csr_wr && !csr_flag_val && csr_busy_val && bank_busy) |=> bank_busy);

  // R6: a busy clear hands the bank back
  a_r6_release_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && csr_wr && !csr_busy_val && bank_busy) |=> !bank_busy);

  // R7: a commit and a release on one edge never touch the same bank
  a_r7_distinct_banks: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && release_bank) |-> (wr_bank != rd_bank));

  // R8: the reported count never exceeds the bank depth
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_count <= CW'(DEPTH));

  // R10: a flag clear wins over any same-cycle set
  a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && !csr_flag_val) |=> !pkt_flag);
endmodule

bind oep_out_bank_mgr oep_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .hs_ack(hs_ack), .hs_nak(hs_nak),
  .csr_wr(csr_wr), .csr_flag_val(csr_flag_val), .csr_busy_val(csr_busy_val),
  .pkt_flag(pkt_flag), .bank_busy(bank_busy), .cpu_count(cpu_count),
  .commit(commit), .release_bank(release_bank), .wr_bank(wr_bank), .rd_bank(rd_bank)
);

// File: tb/tb_oep_out_bank_mgr.sv
`timescale 1ns/1ps
module tb_oep_out_bank_mgr;
  localparam int DW    = 8;
  localparam int DEPTH = 8;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_enable = 1'b0, cfg_two_banks = 1'b0, irq_en = 1'b0;
  logic usb_tok = 1'b0, usb_wr = 1'b0, usb_end = 1'b0;
  logic [DW-1:0] usb_wdata = '0;
  logic cpu_rd = 1'b0, csr_wr = 1'b0, csr_flag_val = 1'b1, csr_busy_val = 1'b1;
  logic hs_ack, hs_nak, pkt_flag, bank_busy, irq;
  logic [DW-1:0] cpu_rdata;
  logic [CW-1:0] cpu_count;

  always #5 clk = ~clk;

  oep_out_bank_mgr #(.DW(DW), .DEPTH(DEPTH)) dut (.*);

  int compared = 0, mismatched = 0;
  bit done = 1'b0;
  string phase = "R1 reset";

  // behavioural reference: queue of completed packet lengths, flat byte stream
  bit m_busy = 0, m_flag = 0, m_rxon = 0;
  int lenq[$];
  logic [7:0] dq[$];
  logic [7:0] cur[$];
  int rdpos = 0;

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s [%s] at %0t: actual %0d expected %0d", tag, phase, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    bit e_end;
    int e_cnt, e_dat;
    e_end = cfg_enable && usb_end && !usb_tok;
    e_cnt = m_busy ? lenq[0] : 0;
    e_dat = (m_busy && rdpos < lenq[0]) ? int'(dq[rdpos]) : 0;
    chk("R2 hs_ack", int'(hs_ack), int'(e_end && m_rxon));
    chk("R2 hs_nak", int'(hs_nak), int'(e_end && !m_rxon));
    chk("R3 pkt_flag", int'(pkt_flag), int'(m_flag));
    chk("R6 bank_busy", int'(bank_busy), int'(m_busy));
    chk("R4 irq", int'(irq), int'(m_flag && irq_en));
    chk("R8 cpu_count", int'(cpu_count), e_cnt);
    chk("R9 cpu_rdata", int'(cpu_rdata), e_dat);
  endtask

  task automatic model_step();
    bit clrf, clrb, rel, pres, free;
    int cap;
    if (!cfg_enable) begin
      m_busy = 0; m_flag = 0; m_rxon = 0; rdpos = 0;
      lenq.delete(); dq.delete(); cur.delete();
      return;
    end
    cap  = cfg_two_banks ? 2 : 1;
    free = lenq.size() < cap;
    clrf = csr_wr && !csr_flag_val;
    clrb = csr_wr && !csr_busy_val;
    rel  = clrb && m_busy;
    pres = !m_busy && lenq.size() > 0 && !clrb;
    // processor side (uses the pre-edge queue)
    if (rel) begin
      for (int i = 0; i < lenq[0]; i++) void'(dq.pop_front());
      void'(lenq.pop_front());
      m_busy = 0; rdpos = 0;
    end else if (pres) begin
      m_busy = 1; rdpos = 0;
    end else if (cpu_rd && m_busy && rdpos < lenq[0]) begin
      rdpos++;
    end
    m_flag = clrf ? 1'b0 : (pres ? 1'b1 : m_flag);
    // receive side
    if (usb_tok) begin
      m_rxon = free; cur.delete();
    end else if (usb_end) begin
      if (m_rxon) begin
        lenq.push_back(cur.size());
        foreach (cur[i]) dq.push_back(cur[i]);
      end
      m_rxon = 0; cur.delete();
    end else if (usb_wr && m_rxon && cur.size() < DEPTH) begin
      cur.push_back(usb_wdata);
    end
  endtask

  task automatic tick();
    #4;
    compare_all();
    model_step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic send_pkt(input int n, input logic [7:0] base, input bit rel_at_end);
    usb_tok = 1; tick(); usb_tok = 0;
    for (int i = 0; i < n; i++) begin
      usb_wr = 1; usb_wdata = base + 8'(i); tick();
    end
    usb_wr = 0;
    usb_end = 1;
    if (rel_at_end) begin csr_wr = 1; csr_busy_val = 0; end
    tick();
    usb_end = 0; csr_wr = 0; csr_busy_val = 1;
  endtask

  task automatic csr(input logic f, input logic b);
    csr_wr = 1; csr_flag_val = f; csr_busy_val = b; tick();
    csr_wr = 0; csr_flag_val = 1; csr_busy_val = 1;
  endtask

  task automatic read_n(input int n);
    cpu_rd = 1; idle(n); cpu_rd = 0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog R2 [%s]: actual hung expected finished", phase);
      finish_run();
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    // reset state (R1)
    #4;
    chk("R1 reset pkt_flag", int'(pkt_flag), 0);
    chk("R1 reset bank_busy", int'(bank_busy), 0);
    chk("R1 reset irq", int'(irq), 0);
    chk("R1 reset cpu_count", int'(cpu_count), 0);
    @(negedge clk);

    phase = "R1 unconfigured";
    send_pkt(3, 8'h10, 0); idle(2);

    cfg_enable = 1; irq_en = 1;
    phase = "R8 single bank packet"; send_pkt(3, 8'h20, 0); idle(2);
    phase = "R9 read past end";      read_n(5);
    phase = "R5 flag only clear";    csr(0, 1); idle(1);
    phase = "R6 release";            csr(1, 0); idle(2);
    phase = "R8 zero length";        send_pkt(0, 8'h30, 0); idle(2); csr(0, 0); idle(1);
    phase = "R8 overflow";           send_pkt(10, 8'h40, 0); idle(2); read_n(9); csr(0, 0);
    phase = "R7 single bank nak";    send_pkt(2, 8'h50, 0); idle(2); send_pkt(1, 8'h60, 0);
    csr(0, 0); idle(2);

    cfg_enable = 0; tick(); cfg_two_banks = 1; cfg_enable = 1;
    phase = "R7 two bank alternate";
    send_pkt(2, 8'h70, 0); send_pkt(3, 8'h80, 0); send_pkt(1, 8'h90, 0); idle(1);
    read_n(2);
    phase = "R6 next bank presented"; csr(0, 0); idle(2); read_n(3); csr(0, 0); idle(1);

    phase = "R10 clear beats flag set"; send_pkt(2, 8'hA0, 0); csr(0, 1); idle(1);
    phase = "R10 write ones ignored";   csr(1, 1); idle(1); csr(1, 0); idle(1);
    phase = "R10 clear beats presentation"; send_pkt(1, 8'hB0, 0); csr(1, 0); idle(2);
    csr(0, 0); idle(1);

    phase = "R7 commit with release"; send_pkt(2, 8'hC0, 0); idle(2);
    send_pkt(2, 8'hD0, 1); idle(3); read_n(2); csr(0, 0); idle(1);

    phase = "R4 irq masked"; irq_en = 0; send_pkt(1, 8'hE0, 0); idle(2);
    irq_en = 1; idle(1); csr(0, 0); idle(1);

    phase = "R1 disable mid packet";
    usb_tok = 1; tick(); usb_tok = 0;
    usb_wr = 1; usb_wdata = 8'hF0; tick(); usb_wr = 0;
    cfg_enable = 0; tick(); cfg_enable = 1;
    usb_end = 1; tick(); usb_end = 0; idle(2);

    done = 1;
    finish_run();
  end
endmodule